// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a dividend by a 16-bit divisor over a fixed number of clock cycles. It returns a 16-bit quotient and a 16-bit remainder. The dividend is either 32 bits wide, given as a high word and a low word, or 16 bits wide, taken from the low word alone. Both widths work in signed or unsigned form. All four forms share one restoring shift-subtract datapath. Signed operands are reduced to magnitudes on entry, and the signs are put back on the last iteration.

A caller pulses `start` with the operands and a two-bit mode while `busy` is low. The block retires one quotient bit per clock, so every operation takes one cycle per divisor bit, whatever the mode. `done` then pulses for one cycle. The results and the error flag stay on their ports until the next `done`. A zero divisor, or a quotient that cannot be represented in 16 bits, raises `error` in place of a result.

Top module: `iter_divider`

## Requirements
- R1: The mode field selects the operation. Bit 0 set means signed operands. Bit 1 set means a 16/16 divide on the low word; bit 1 clear means a 32/16 divide on {dvd_hi, dvd_lo}. In unsigned forms, quotient and remainder satisfy dividend = quotient*divisor + remainder, with remainder < divisor.
- R2: In signed forms the quotient is truncated toward zero. A nonzero remainder carries the sign of the dividend, and its magnitude is below the divisor magnitude.
- R3: `done` rises exactly 16 clock edges after the edge that accepted `start`, in all four modes. `busy` is high for those 16 cycles.
- R4: `done` is high for a single cycle, and `busy` and `done` are never high together.
- R5: A `start` seen while `busy` is high is ignored. The running operation finishes with its own operands, and no extra result is produced.
- R6: A zero divisor sets `error` and drives quotient and remainder to 0, with `done` at the normal latency.
- R7: A quotient outside 0..65535 (unsigned) or outside -32768..32767 (signed) sets `error` and zeroes both result ports. This covers large 32/16 quotients and -32768 / -1 in 16/16 signed mode.
- R8: In 16/16 modes the value on `dvd_hi` has no effect on the results.
- R9: During reset `busy`, `done`, `error`, `quotient` and `remainder` are all 0.
- R10: Quotient, remainder and error hold their values from one `done` until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| mode | input | 2 | Bit 0: signed; bit 1: 16/16 form |
| dvd_hi | input | 16 | High word of the 32-bit dividend |
| dvd_lo | input | 16 | Low word of the dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| error | output | 1 | Divide by zero or quotient overflow |

## Verification
The hardest case to reach is the boundary of signed overflow. A quotient magnitude of exactly 32768 is legal when the result is negative and illegal when it is positive. Random operands almost never land on that value. The stimulus therefore adds directed operand pairs that produce +32768 and -32768 in both dividend widths, together with the most negative dividend over -1. It also sets the 32/16 unsigned high word one below and exactly at the divisor, so the entry overflow test is exercised on both sides.

// File: rtl/divu_pkg.sv
package divu_pkg;
    parameter int WORD  = 16;
    localparam int DWORD = 2 * WORD;
    localparam int CNT_W = $clog2(WORD);

    typedef enum logic [1:0] {
        MODE_U32 = 2'b00,
        MODE_S32 = 2'b01,
        MODE_U16 = 2'b10,
        MODE_S16 = 2'b11
    } div_mode_e;

    typedef logic [WORD-1:0] word_t;

    // Working state of one division: partial remainder, shifting dividend /
    // quotient word, divisor magnitude, and the sign and error flags.
    typedef struct packed {
        word_t part;
        word_t low;
        word_t dvs;
        logic  neg_q;
        logic  neg_r;
        logic  sgn;
        logic  pre_err;
    } div_op_t;

    function automatic word_t neg_if(word_t v, logic n);
        return n ? (word_t'(0) - v) : v;
    endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep
    import divu_pkg::*;
(
    input  logic [1:0]  mode,
    input  word_t       hi,
    input  word_t       lo,
    input  word_t       den,
    output div_op_t     op
);
    logic              is_sig;
    logic              is_short;
    logic [DWORD-1:0]  num;
    logic [DWORD-1:0]  num_mag;
    logic              num_neg;
    logic              den_neg;
    word_t             den_mag;

    always_comb begin
        is_sig   = mode[0];
        is_short = mode[1];
        if (is_short)
            num = {{WORD{is_sig & lo[WORD-1]}}, lo};
        else
            num = {hi, lo};
        num_neg = is_sig & num[DWORD-1];
        num_mag = num_neg ? (DWORD'(0) - num) : num;
        den_neg = is_sig & den[WORD-1];
        den_mag = neg_if(den, den_neg);

        op.part    = num_mag[DWORD-1:WORD];
        op.low     = num_mag[WORD-1:0];
        op.dvs     = den_mag;
        op.neg_q   = num_neg ^ den_neg;
        op.neg_r   = num_neg;
        op.sgn     = is_sig;
        // upper half not below divisor: quotient needs more than WORD bits
        op.pre_err = (den_mag == '0) || (num_mag[DWORD-1:WORD] >= den_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step
    import divu_pkg::*;
(
    input  word_t part,
    input  word_t low,
    input  word_t dvs,
    output word_t part_n,
    output word_t low_n
);
    logic [WORD:0] trial;
    logic [WORD:0] diff;

    always_comb begin
        trial = {part, low[WORD-1]};
        diff  = trial - {1'b0, dvs};
        if (trial >= {1'b0, dvs}) begin
            part_n = diff[WORD-1:0];
            low_n  = {low[WORD-2:0], 1'b1};
        end else begin
            part_n = trial[WORD-1:0];
            low_n  = {low[WORD-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/div_post.sv
module div_post
    import divu_pkg::*;
(
    input  word_t q_mag,
    input  word_t r_mag,
    input  logic  neg_q,
    input  logic  neg_r,
    input  logic  sgn,
    input  logic  pre_err,
    output word_t quot,
    output word_t rem,
    output logic  err
);
    localparam word_t HALF = word_t'(1) << (WORD - 1);
    logic over_s;

    always_comb begin
        over_s = sgn & (neg_q ? (q_mag > HALF) : q_mag[WORD-1]);
        err    = pre_err | over_s;
        quot   = err ? '0 : neg_if(q_mag, neg_q);
        rem    = err ? '0 : neg_if(r_mag, neg_r);
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import divu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  mode,
    input  logic [15:0] dvd_hi,
    input  logic [15:0] dvd_lo,
    input  logic [15:0] divisor,
    output logic        busy,
    output logic        done,
    output logic [15:0] quotient,
    output logic [15:0] remainder,
    output logic        error
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD - 1);

    div_op_t          prep_op;
    div_op_t          op_r;
    logic [CNT_W-1:0] cnt_r;
    logic             busy_r;
    logic             done_r;
    word_t            quot_r;
    word_t            rem_r;
    logic             err_r;
    word_t            step_part;
    word_t            step_low;
    word_t            post_q;
    word_t            post_r;
    logic             post_err;
    logic             accept;

    assign accept = start & ~busy_r;

    div_prep u_prep (
        .mode (mode),
        .hi   (dvd_hi),
        .lo   (dvd_lo),
        .den  (divisor),
        .op   (prep_op)
    );

    div_step u_step (
        .part   (op_r.part),
        .low    (op_r.low),
        .dvs    (op_r.dvs),
        .part_n (step_part),
        .low_n  (step_low)
    );

    div_post u_post (
        .q_mag   (step_low),
        .r_mag   (step_part),
        .neg_q   (op_r.neg_q),
        .neg_r   (op_r.neg_r),
        .sgn     (op_r.sgn),
        .pre_err (op_r.pre_err),
        .quot    (post_q),
        .rem     (post_r),
        .err     (post_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_r   <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
            quot_r <= '0;
            rem_r  <= '0;
            err_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (accept) begin
                op_r   <= prep_op;
                cnt_r  <= '0;
                busy_r <= 1'b1;
            end else if (busy_r) begin
                op_r.part <= step_part;
                op_r.low  <= step_low;
                cnt_r     <= cnt_r + 1'b1;
                if (cnt_r == LAST) begin
                    busy_r <= 1'b0;
                    done_r <= 1'b1;
                    quot_r <= post_q;
                    rem_r  <= post_r;
                    err_r  <= post_err;
                end
            end
        end
    end

    assign busy      = busy_r;
    assign done      = done_r;
    assign quotient  = quot_r;
    assign remainder = rem_r;
    assign error     = err_r;

    // independent run-length counter for the latency check
    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (accept)  run_len <= '0;
        else if (busy_r)  run_len <= run_len + 1'b1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_r |-> (run_len == (CNT_W+1)'(WORD)));                                        // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_r |=> !done_r);                                                              // R4
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_r && done_r));                                                             // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_r && start) |=> ($stable(op_r.dvs) && $stable(op_r.sgn) && $stable(op_r.neg_r))); // R5
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done_r && !err_r) |-> (neg_if(rem_r, op_r.neg_r) < op_r.dvs));                   // R1
    AST_REM_SIGN: assert property (@(posedge clk) disable iff (rst)
        (done_r && !err_r && op_r.sgn && rem_r != '0) |-> (rem_r[WORD-1] == op_r.neg_r));  // R2
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (done_r && op_r.dvs == '0) |-> (err_r && quot_r == '0 && rem_r == '0));            // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_r |-> ($stable(quot_r) && $stable(rem_r) && $stable(err_r)));                // R10
endmodule

// File: tb/iter_divider_test.sv
`timescale 1ns/1ps
module iter_divider_test;
    import divu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic        busy, done, error;
    logic [15:0] quotient, remainder;

    always #2 clk = ~clk;   // 250 MHz

    iter_divider uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .error(error)
    );

    typedef struct {
        logic [15:0] q;
        logic [15:0] r;
        logic        e;
        int          acc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [15:0] last_q = '0, last_r = '0;
    logic        last_e = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t ref_div(input logic [1:0] m, input logic [15:0] h,
                                     input logic [15:0] l, input logic [15:0] d);
        exp_t   x;
        longint n, dd, q, r;
        logic   sg = m[0];
        logic   err = 1'b0;
        if (m[1]) n = sg ? longint'($signed(l)) : longint'(l);
        else      n = sg ? longint'($signed({h, l})) : longint'({h, l});
        dd = sg ? longint'($signed(d)) : longint'(d);
        q = 0; r = 0;
        if (dd == 0) err = 1'b1;
        else begin
            q = n / dd;
            r = n % dd;
            if (sg) err = (q > 32767) || (q < -32768);
            else    err = (q > 65535);
        end
        x.q = err ? 16'h0 : q[15:0];
        x.r = err ? 16'h0 : r[15:0];
        x.e = err;
        x.acc = 0;
        x.tag = "";
        return x;
    endfunction

    // driver: waits for idle, drives one operation, pushes expectation
    task automatic issue(input logic [1:0] m, input logic [15:0] h, input logic [15:0] l,
                         input logic [15:0] d, input string tag);
        exp_t x;
        x = ref_div(m, h, l, d);
        x.tag = tag;
        @(negedge clk);
        while (busy) @(negedge clk);
        mode = m; dvd_hi = h; dvd_lo = l; divisor = d; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        x.acc = cyc;
        sb_q.push_back(x);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            if (busy && done) check(1'b0, "R4", "busy and done together", 1, 0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected result", 1, 0);
                end else begin
                    x = sb_q.pop_front();
                    check(error == x.e, x.tag, "error", error, x.e);
                    check(quotient == x.q, x.tag, "quotient", quotient, x.q);
                    check(remainder == x.r, x.tag, "remainder", remainder, x.r);
                    check(cyc - x.acc == 16, "R3", "latency", cyc - x.acc, 16);
                    last_q = quotient; last_r = remainder; last_e = error;
                    @(negedge clk);
                    check(!done, "R4", "done width", done, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy == 0 && done == 0 && error == 0, "R9", "control during reset",
              {busy, done, error}, 0);
        check(quotient == 0 && remainder == 0, "R9", "results during reset",
              {quotient, remainder}, 0);
        rst = 1'b0;

        // R1 unsigned 32/16 corners, R7 overflow boundary on the entry test
        issue(MODE_U32, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R1");
        issue(MODE_U32, 16'h0001, 16'h0000, 16'h0001, "R7");
        issue(MODE_U32, 16'h1233, 16'h5678, 16'h1234, "R1");
        issue(MODE_U32, 16'h1234, 16'h0000, 16'h1234, "R7");
        // R6 zero divisor in every mode
        issue(MODE_U32, 16'h0000, 16'h0005, 16'h0000, "R6");
        issue(MODE_S32, 16'hFFFF, 16'hFFF0, 16'h0000, "R6");
        issue(MODE_U16, 16'h0000, 16'h0000, 16'h0000, "R6");
        issue(MODE_S16, 16'h0000, 16'h8000, 16'h0000, "R6");
        // R2 signed truncation and remainder sign
        issue(MODE_S32, 16'hFFFF, 16'hFFF9, 16'h0002, "R2");
        issue(MODE_S32, 16'h0000, 16'h0007, 16'hFFFE, "R2");
        issue(MODE_S16, 16'h0000, 16'hFFF9, 16'hFFFE, "R2");
        issue(MODE_S16, 16'h0000, 16'h0007, 16'hFFFE, "R2");
        // R7 signed magnitude 32768 on both sides of zero
        issue(MODE_S32, 16'hFFFF, 16'h0000, 16'h0002, "R7");
        issue(MODE_S32, 16'h0001, 16'h0000, 16'h0002, "R7");
        issue(MODE_S32, 16'h8000, 16'h0000, 16'hFFFF, "R7");
        issue(MODE_S32, 16'h0000, 16'h8000, 16'hFFFF, "R7");
        issue(MODE_S16, 16'h0000, 16'h8000, 16'hFFFF, "R7");
        issue(MODE_S16, 16'h0000, 16'h8000, 16'h0001, "R2");
        // R8 high word ignored in 16/16 modes
        issue(MODE_U16, 16'hDEAD, 16'hFFFF, 16'h0001, "R8");
        issue(MODE_U16, 16'hBEEF, 16'h0005, 16'h0007, "R8");
        issue(MODE_S16, 16'hFFFF, 16'h0064, 16'h0007, "R8");

        // R1/R2 random operands in all four modes
        for (int i = 0; i < 160; i++) begin
            logic [15:0] d, h, l;
            logic [1:0]  m;
            m = 2'(i % 4);
            d = 16'($urandom);
            if (i % 11 == 0) d = 16'h0001;
            if (d == 0) d = 16'h0003;
            l = 16'($urandom);
            h = 16'($urandom);
            if (m == MODE_U32 && (i % 3 != 0)) h = h % d;
            if (m == MODE_S32 && (i % 3 != 0)) h = {16{l[15]}};
            issue(m, h, l, d, m[0] ? "R2" : "R1");
        end
        wait_idle();

        // R5: start while busy is ignored
        issue(MODE_U16, 16'h0000, 16'h0064, 16'h0003, "R5");
        repeat (4) @(negedge clk);
        mode = MODE_U16; dvd_lo = 16'h0009; divisor = 16'h0002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0 && !busy, "R5", "extra operation", busy, 0);
        check(quotient == 16'd33 && remainder == 16'd1, "R5", "result of first op",
              {quotient, remainder}, {16'd33, 16'd1});

        // R10: results hold while inputs move
        issue(MODE_S32, 16'hFFFF, 16'hFF00, 16'h0010, "R2");
        wait_idle();
        dvd_lo = 16'h1111; divisor = 16'h0000; mode = MODE_U32;
        repeat (6) @(negedge clk);
        check(quotient == last_q && remainder == last_r && error == last_e, "R10",
              "outputs held", {quotient, remainder}, {last_q, last_r});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule